// File: doc/BRIEF.md
# Two-Step Converter Digital Error Corrector

This block is the digital back end of a two-pass subranging analog-to-digital converter. The first pass gives a 7-bit coarse flash code, which the block holds while the analog side builds and amplifies the residue by 32. The second pass gives a 7-bit fine flash code. The block weights the coarse code by 32, adds the fine code, and subtracts a fixed redundancy offset of 48. The fine range overlaps the coarse step, so a coarse decision that is off by up to about one and a half coarse steps still yields the right word.

The corrected 12-bit result is offset binary: 2048 is the input midpoint and 0 is the bottom of the range. A sum above the top of the range or below zero is clamped and flagged as overflow. A separate bit gives the direction of the overflow. The result sits in an output register that changes only when a fine strobe has been taken, and a one-cycle ready pulse marks each new result.

Top module: `subr_err_correct`

## Requirements
- R1: During and right after synchronous reset, result_word is 0, result_ovf is 0, result_over is 0 and result_ready is 0.
- R2: For an in-range sum, result_word equals coarse*32 + fine - 48 as an unsigned 12-bit offset-binary value. For example, coarse 64 with fine 48 gives 2048, and coarse 63 with fine 80 also gives 2048.
- R3: The coarse code is taken only on a clock where coarse_valid is 1. Changes on coarse_code at other times are ignored. A held coarse code is reused by every later fine strobe until the next coarse strobe.
- R4: A sum above 4095 gives result_word 4095 (all ones), with result_ovf 1 and result_over 1.
- R5: A sum below 0 gives result_word 0, with result_ovf 1 and result_over 0.
- R6: For an in-range sum, result_ovf is 0 and result_over is 0. result_over is never 1 while result_ovf is 0.
- R7: If fine_valid is sampled at clock edge N, the outputs take the new result at edge N+1, and result_ready is 1 for exactly the one cycle after edge N+1.
- R8: With no fine strobe, the outputs hold their last values. Changes on fine_code at other times are ignored.
- R9: The exact range edges are in range: a sum of 0 (coarse 1, fine 16) and a sum of 4095 (coarse 127, fine 79) set no overflow. A sum of 4096 (coarse 127, fine 80) does set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_valid | input | 1 | Strobe to take the coarse flash code |
| coarse_code | input | 7 | First-pass flash code |
| fine_valid | input | 1 | Strobe marking the fine flash code as valid |
| fine_code | input | 7 | Second-pass flash code of the amplified residue |
| result_word | output | 12 | Corrected offset-binary word |
| result_ovf | output | 1 | Overrange or underrange flag |
| result_over | output | 1 | Overflow direction: 1 above the range, 0 below it |
| result_ready | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
A coarse latch that held the wrong value would show up on the next conversion: the word would be off by an exact multiple of 32, one cycle after the fine strobe. An error in the offset, the weighting or the clamp would show as a wrong word or a wrong flag pair at the two range edges and in the overrange cases. A slip in the staging would move the ready pulse or the word change away from the edge after the fine strobe. It would also make the outputs move during gaps when they should hold.

// File: rtl/subr_pkg.sv
package subr_pkg;
    localparam int FLASH_W    = 7;
    localparam int OUT_W      = 12;
    localparam int GAIN_SHIFT = 5;
    localparam int REDUND_OFS = 48;
    localparam int SUM_W      = FLASH_W + GAIN_SHIFT + 2;
    localparam int CODE_TOP   = (1 << OUT_W) - 1;

    typedef enum logic [1:0] {
        RNG_IN    = 2'd0,
        RNG_OVER  = 2'd1,
        RNG_UNDER = 2'd2
    } range_e;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             ovf;
        logic             over;
    } result_t;

    function automatic range_e classify(input logic [SUM_W-1:0] raw);
        if (raw[SUM_W-1])
            return RNG_UNDER;
        else if (raw > SUM_W'(CODE_TOP))
            return RNG_OVER;
        else
            return RNG_IN;
    endfunction
endpackage

// File: rtl/subr_coarse_hold.sv
module subr_coarse_hold
    import subr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FLASH_W-1:0] code_in,
    output logic [FLASH_W-1:0] code_held
);
    always_ff @(posedge clk) begin
        if (rst)
            code_held <= '0;
        else if (load)
            code_held <= code_in;
    end

    AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code_held)); // R3
endmodule

// File: rtl/subr_combine.sv
module subr_combine
    import subr_pkg::*;
(
    input  logic [FLASH_W-1:0] coarse,
    input  logic [FLASH_W-1:0] fine,
    output result_t            res
);
    logic [SUM_W-1:0] raw;
    range_e           rng;

    always_comb begin
        raw = ({{(SUM_W-FLASH_W){1'b0}}, coarse} << GAIN_SHIFT)
            + {{(SUM_W-FLASH_W){1'b0}}, fine}
            - SUM_W'(REDUND_OFS);
        rng = classify(raw);
        unique case (rng)
            RNG_OVER:  res = '{word: '1, ovf: 1'b1, over: 1'b1};
            RNG_UNDER: res = '{word: '0, ovf: 1'b1, over: 1'b0};
            default:   res = '{word: raw[OUT_W-1:0], ovf: 1'b0, over: 1'b0};
        endcase
    end
endmodule

// File: rtl/subr_out_reg.sv
module subr_out_reg
    import subr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  result_t res_in,
    output result_t res_q,
    output logic    ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ready <= 1'b0;
        end else begin
            ready <= load;
            if (load)
                res_q <= res_in;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(res_q)); // R8
endmodule

// File: rtl/subr_err_correct.sv
module subr_err_correct
    import subr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               coarse_valid,
    input  logic [FLASH_W-1:0] coarse_code,
    input  logic               fine_valid,
    input  logic [FLASH_W-1:0] fine_code,
    output logic [OUT_W-1:0]   result_word,
    output logic               result_ovf,
    output logic               result_over,
    output logic               result_ready
);
    logic [FLASH_W-1:0] coarse_q;
    logic [FLASH_W-1:0] fine_q;
    logic               load_q;
    result_t            comb_res;
    result_t            out_res;

    subr_coarse_hold u_coarse (
        .clk(clk), .rst(rst), .load(coarse_valid),
        .code_in(coarse_code), .code_held(coarse_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= fine_valid;
            if (fine_valid)
                fine_q <= fine_code;
        end
    end

    subr_combine u_comb (.coarse(coarse_q), .fine(fine_q), .res(comb_res));

    subr_out_reg u_out (
        .clk(clk), .rst(rst), .load(load_q),
        .res_in(comb_res), .res_q(out_res), .ready(result_ready)
    );

    assign result_word = out_res.word;
    assign result_ovf  = out_res.ovf;
    assign result_over = out_res.over;

    AST_OVER_SAT: assert property (@(posedge clk) disable iff (rst)
        (result_ovf && result_over) |-> (result_word == '1)); // R4
    AST_UNDER_SAT: assert property (@(posedge clk) disable iff (rst)
        (result_ovf && !result_over) |-> (result_word == '0)); // R5
    AST_POL_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
        !result_ovf |-> !result_over); // R6
    AST_READY_TIMING: assert property (@(posedge clk) disable iff (rst)
        fine_valid |=> ##1 result_ready); // R7
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_ready |=> !result_ready || $past(fine_valid)); // R7
endmodule

// File: tb/subr_err_correct_tb_top.sv
module subr_err_correct_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        coarse_valid;
    logic [6:0]  coarse_code;
    logic        fine_valid;
    logic [6:0]  fine_code;
    logic [11:0] result_word;
    logic        result_ovf;
    logic        result_over;
    logic        result_ready;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    subr_err_correct dut_i (
        .clk(clk), .rst(rst),
        .coarse_valid(coarse_valid), .coarse_code(coarse_code),
        .fine_valid(fine_valid), .fine_code(fine_code),
        .result_word(result_word), .result_ovf(result_ovf),
        .result_over(result_over), .result_ready(result_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_res(input string req, input int c, input int f);
        int s = c * 32 + f - 48;
        int w = (s > 4095) ? 4095 : ((s < 0) ? 0 : s);
        chk(req, "word", int'(result_word), w);
        chk(req, "ovf", int'(result_ovf), (s > 4095 || s < 0) ? 1 : 0);
        chk(req, "over", int'(result_over), (s > 4095) ? 1 : 0);
    endtask

    task automatic load_coarse(input int c);
        @(negedge clk);
        coarse_code = 7'(c);
        coarse_valid = 1'b1;
        @(negedge clk);
        coarse_valid = 1'b0;
        coarse_code = 7'(c ^ 7'h55);
    endtask

    task automatic fire_fine(input int f);
        fine_code = 7'(f);
        fine_valid = 1'b1;
        @(negedge clk);
        fine_valid = 1'b0;
        fine_code = 7'(f ^ 7'h2A);
    endtask

    task automatic convert(input string req, input int c, input int f);
        load_coarse(c);
        fire_fine(f);
        chk("R7", "ready before load", int'(result_ready), 0);
        @(negedge clk);
        chk("R7", "ready pulse", int'(result_ready), 1);
        expect_res(req, c, f);
        @(negedge clk);
        chk("R7", "ready single", int'(result_ready), 0);
    endtask

    task automatic t_reset();
        chk("R1", "word", int'(result_word), 0);
        chk("R1", "ovf", int'(result_ovf), 0);
        chk("R1", "over", int'(result_over), 0);
        chk("R1", "ready", int'(result_ready), 0);
    endtask

    task automatic t_in_range();
        convert("R2", 64, 48);
        convert("R2", 63, 80);
        convert("R2", 10, 5);
        convert("R6", 100, 100);
    endtask

    task automatic t_coarse_hold();
        load_coarse(40);
        coarse_code = 7'd3;
        @(negedge clk);
        fire_fine(60);
        @(negedge clk);
        expect_res("R3", 40, 60);
        fine_code = 7'd7;
        fire_fine(7);
        @(negedge clk);
        expect_res("R3", 40, 7);
    endtask

    task automatic t_over();
        convert("R4", 127, 127);
        convert("R4", 127, 80);
    endtask

    task automatic t_under();
        convert("R5", 0, 0);
        convert("R5", 1, 15);
    endtask

    task automatic t_edges();
        convert("R9", 1, 16);
        convert("R9", 127, 79);
    endtask

    task automatic t_hold();
        convert("R8", 50, 20);
        for (int i = 0; i < 6; i++) begin
            fine_code = 7'(i * 19);
            @(negedge clk);
            expect_res("R8", 50, 20);
        end
    endtask

    initial begin
        rst = 1'b1;
        coarse_valid = 1'b0;
        fine_valid = 1'b0;
        coarse_code = '0;
        fine_code = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_in_range();
        t_coarse_hold();
        t_over();
        t_under();
        t_edges();
        t_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule